// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block powers a contact smart card up and down in a fixed, interlocked order. The host asks for power with an active-low command. A card-present flag and a vector of fault flags from the analog supervisors qualify that request. On activation the sequencer raises five enables one at a time: the step-up supply, the card VCC regulator, the I/O transceivers, the card clock buffer and, last, the release of card reset. The last step lets the card start its software. A shared tick counter spaces the steps `STEP_TICKS` clock cycles apart.

On teardown the enables fall in the reverse order. Card reset is asserted first, then the clock stops, then the I/O drivers go to high impedance ahead of the supply fall, then VCC is removed, and finally the step-up supply is disabled. The host starts a teardown by raising the command. A card removal or a fault during power-up or while the card is active also starts a teardown at once, and in that case a sticky alarm is set.

A teardown that has begun always runs to completion. The next power-up can only begin once all enables are low.

Top module: `card_power_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all five enables and `alarm` are low.
- R2: From the idle state (all enables low), power-up starts only when, at a clock edge, `card_present` is 1, `pwr_cmd_n` is 0 and every `fault` bit is 0. When it starts, `supply_en` is high from that edge onward. Otherwise all enables stay low.
- R3: During power-up the enables rise in this order: `supply_en`, `vcc_en`, `io_en`, `clk_en`, `rst_rel`. Each rises exactly `STEP_TICKS` cycles after the previous one.
- R4: Once `rst_rel` is high, all five enables stay high for as long as `pwr_cmd_n` is 0, `card_present` is 1 and no fault bit is set.
- R5: When `pwr_cmd_n` is seen high during power-up or while active, the highest raised enable falls at that same edge. The remaining enables then fall one every `STEP_TICKS` cycles, in the order `rst_rel`, `clk_en`, `io_en`, `vcc_en`, `supply_en`. The block is idle once `supply_en` is low.
- R6: When `card_present` is 0 or any `fault` bit is 1 at an edge during power-up or while active, the teardown of R5 starts at that edge and `alarm` goes high at the same edge.
- R7: `alarm` stays high until the next power-up is accepted under R2, and it goes low at that same edge.
- R8: During a teardown, `pwr_cmd_n`, `card_present` and `fault` have no effect: no enable rises, the pace stays at one step every `STEP_TICKS` cycles, and `alarm` does not change.
- R9: At most one enable changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | 1 when a card is inserted |
| pwr_cmd_n | input | 1 | Host power command, 0 requests power |
| fault | input | FAULT_W | Fault flags, any 1 is a fault |
| supply_en | output | 1 | Step-up supply enable |
| vcc_en | output | 1 | Card VCC regulator enable |
| io_en | output | 1 | I/O transceiver enable, 0 means high impedance |
| clk_en | output | 1 | Card clock buffer enable |
| rst_rel | output | 1 | 1 releases card reset |
| alarm | output | 1 | Sticky abort flag |

## Verification
The bench builds the block with `STEP_TICKS` = 3 and `FAULT_W` = 2. With these values a full power-up plus teardown fits in about 30 cycles, so a few thousand random cycles land removals, faults and command flips on every step of both ramps. Both fault bits are driven separately and together, so the wide OR is covered. A short step count also makes it cheap to cover the case where a request arrives in the middle of a teardown, and the restart that follows once the teardown reaches idle.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned STAGES = 5;
  typedef logic [2:0] level_t;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_ON   = 2'd2,
    ST_DOWN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic step
);
  localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (step)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_ok,
  input  logic       abort,
  input  logic       off_req,
  input  logic       step,
  output logic       restart,
  output level_t     lvl_nxt,
  output logic       alarm_q
);
  localparam level_t TOP = level_t'(STAGES);

  seq_state_t st_q, st_n;
  level_t     lvl_q;
  logic       alarm_n;

  always_comb begin
    st_n    = st_q;
    lvl_nxt = lvl_q;
    restart = 1'b0;
    alarm_n = alarm_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          lvl_nxt = level_t'(1);
          st_n    = ST_UP;
          restart = 1'b1;
          alarm_n = 1'b0;
        end
      end
      ST_UP, ST_ON: begin
        if (abort || off_req) begin
          if (abort) alarm_n = 1'b1;
          lvl_nxt = lvl_q - 1'b1;
          restart = 1'b1;
          st_n    = (lvl_q == level_t'(1)) ? ST_IDLE : ST_DOWN;
        end else if (st_q == ST_UP && step) begin
          lvl_nxt = lvl_q + 1'b1;
          st_n    = (lvl_q == TOP - 1'b1) ? ST_ON : ST_UP;
        end
      end
      ST_DOWN: begin
        if (step) begin
          lvl_nxt = lvl_q - 1'b1;
          if (lvl_q == level_t'(1)) st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      lvl_q   <= lvl_nxt;
      alarm_q <= alarm_n;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !start_ok) |=> (lvl_q == '0));

  // R6
  abort_response_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_UP || st_q == ST_ON) && abort) |=>
      (alarm_q && lvl_q == $past(lvl_q) - 1'b1));

  // R7
  alarm_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> $past(abort));

  // R8
  down_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DOWN) |=> (lvl_q <= $past(lvl_q) && alarm_q == $past(alarm_q)));

  // R4
  on_full_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON) |-> (lvl_q == TOP));
endmodule

// File: rtl/cps_stage_out.sv
module cps_stage_out
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  level_t            lvl_nxt,
  output logic [STAGES-1:0] en_q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b0;
      else     en_q[i] <= (lvl_nxt > level_t'(i));
    end
  end

  // R9
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(en_q ^ $past(en_q)) <= 1);
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import cps_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 16,
  parameter int unsigned FAULT_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               card_present,
  input  logic               pwr_cmd_n,
  input  logic [FAULT_W-1:0] fault,
  output logic               supply_en,
  output logic               vcc_en,
  output logic               io_en,
  output logic               clk_en,
  output logic               rst_rel,
  output logic               alarm
);
  logic              abort, start_ok, restart, step;
  level_t            lvl_nxt;
  logic [STAGES-1:0] en_q;

  assign abort    = (|fault) || !card_present;
  assign start_ok = !abort && !pwr_cmd_n;

  cps_step_timer #(.TICKS(STEP_TICKS)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .step(step)
  );

  cps_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_ok(start_ok), .abort(abort),
    .off_req(pwr_cmd_n), .step(step), .restart(restart),
    .lvl_nxt(lvl_nxt), .alarm_q(alarm)
  );

  cps_stage_out u_out (
    .clk(clk), .rst(rst), .lvl_nxt(lvl_nxt), .en_q(en_q)
  );

  assign supply_en = en_q[0];
  assign vcc_en    = en_q[1];
  assign io_en     = en_q[2];
  assign clk_en    = en_q[3];
  assign rst_rel   = en_q[4];

  // R6
  alarm_io_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm)) |-> !rst_rel);
endmodule

// File: tb/tb_card_power_seq.sv
`timescale 1ns/1ps
module tb_card_power_seq;
  localparam int T  = 3;
  localparam int FW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_present = 1'b0;
  logic pwr_cmd_n = 1'b1;
  logic [FW-1:0] fault = '0;
  logic supply_en, vcc_en, io_en, clk_en, rst_rel, alarm;

  card_power_seq #(.STEP_TICKS(T), .FAULT_W(FW)) dut (
    .clk(clk), .rst(rst), .card_present(card_present), .pwr_cmd_n(pwr_cmd_n),
    .fault(fault), .supply_en(supply_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .rst_rel(rst_rel), .alarm(alarm)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  string phase = "R2";

  // reference model: 0 idle, 1 ramp up, 2 active, 3 teardown
  int m_st = 0, m_lvl = 0, m_cnt = 0;
  bit m_alarm = 1'b0;
  logic [4:0] prev_en = '0;

  function automatic logic [4:0] expect_en(int lvl);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = (lvl > i);
    return r;
  endfunction

  function automatic string state_tag(int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    bit ab;
    ab = (fault != 0) || !card_present;
    if (rst) begin
      m_st = 0; m_lvl = 0; m_cnt = 0; m_alarm = 0;
    end else begin
      case (m_st)
        0: if (!ab && !pwr_cmd_n) begin
             m_lvl = 1; m_st = 1; m_cnt = 0; m_alarm = 0;
           end
        1, 2: if (ab || pwr_cmd_n) begin
             if (ab) m_alarm = 1;
             m_lvl = m_lvl - 1; m_cnt = 0;
             m_st = (m_lvl == 0) ? 0 : 3;
           end else if (m_st == 1) begin
             if (m_cnt == T - 1) begin
               m_cnt = 0; m_lvl = m_lvl + 1;
               if (m_lvl == 5) m_st = 2;
             end else m_cnt = m_cnt + 1;
           end
        default: if (m_cnt == T - 1) begin
             m_cnt = 0; m_lvl = m_lvl - 1;
             if (m_lvl == 0) m_st = 0;
           end else m_cnt = m_cnt + 1;
      endcase
    end
  end

  task automatic check_cycle();
    logic [4:0] got, exp;
    got = {rst_rel, clk_en, io_en, vcc_en, supply_en};
    exp = expect_en(m_lvl);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s (phase %s): enables got %b expected %b at %0t",
               state_tag(m_st), phase, got, exp, $time);
    end
    n_checks++;
    if (alarm !== m_alarm) begin
      n_errors++;
      $display("FAIL R7 (phase %s): alarm got %b expected %b at %0t",
               phase, alarm, m_alarm, $time);
    end
    n_checks++;
    if ($countones(got ^ prev_en) > 1) begin
      n_errors++;
      $display("FAIL R9: enables went %b -> %b, expected at most one change",
               prev_en, got);
    end
    prev_en = got;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1978));
    // R1: reset state
    phase = "R1";
    run(4);
    rst = 1'b0;
    run(1);
    // R2: fault holds off a request
    phase = "R2";
    card_present = 1'b1; fault = 2'b10; pwr_cmd_n = 1'b0;
    run(6);
    fault = '0;
    // R3, R4: full power-up then hold
    phase = "R3";
    run(5 * T + 2);
    phase = "R4";
    run(10);
    // R5 then R8: request again mid-teardown, plus a fault pulse
    phase = "R5";
    pwr_cmd_n = 1'b1;
    run(T + 1);
    phase = "R8";
    pwr_cmd_n = 1'b0; fault = 2'b01;
    run(1);
    fault = '0; card_present = 1'b0;
    run(2);
    card_present = 1'b1;
    run(5 * T + 4);
    // R6: fault while active
    phase = "R6";
    run(4 * T);
    fault = 2'b11;
    run(1);
    fault = '0; pwr_cmd_n = 1'b1;
    // R7: alarm stays until the next accepted request
    phase = "R7";
    run(6 * T);
    pwr_cmd_n = 1'b0;
    run(2 * T);
    // R6: removal at the second step of a power-up
    phase = "R6";
    pwr_cmd_n = 1'b1;
    run(6 * T);
    pwr_cmd_n = 1'b0;
    run(T + 1);
    card_present = 1'b0;
    run(3 * T);
    card_present = 1'b1;
    // random stimulus
    phase = "rand";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      check_cycle();
      if ($urandom_range(0, 19) == 0) pwr_cmd_n = ~pwr_cmd_n;
      if (card_present && $urandom_range(0, 59) == 0) card_present = 1'b0;
      else if (!card_present && $urandom_range(0, 7) == 0) card_present = 1'b1;
      fault = ($urandom_range(0, 49) == 0) ? FW'($urandom_range(1, 3)) : '0;
    end
    finish_run();
  end
endmodule